// File: doc/BRIEF.md
# Indexed Block Register Slave for a Two-Wire Management Bus

This block is the management-bus target that lets a system controller load and inspect the eight-bit control registers of a clock-buffer device. The serial clock and data lines enter through short synchronizers. The open-drain data line is driven through a single output-enable: when it is high, the pad pulls the line low. The control registers sit inside the block, and their whole contents come out on a flat vector so that the rest of the device can use them.

Every access names a starting register index. A write then gives a byte count and that many data bytes, which land in consecutive registers. A read switches direction with a repeated start and the read address. The target then sends the byte count held in the count register, and after that the registers from the starting index onward. The pointer advances by one after each data byte.

The controller is a single state machine over rising and falling edges of the synchronized serial clock. Its states are:
- `S_IDLE`, waiting for a start.
- `S_ADDR`, `S_INDEX`, `S_COUNT` and `S_WDATA`, each receiving a byte.
- `S_ACK_WADDR`, `S_ACK_RADDR`, `S_ACK_INDEX`, `S_ACK_COUNT` and `S_ACK_WDATA`, each driving an acknowledge bit.
- `S_TX`, sending a byte.
- `S_TX_ACK`, sampling the controller's acknowledge.
- `S_HOLD`, silent until the next start.

The transitions are:
- A start moves any state to `S_ADDR`, and a stop moves any state to `S_IDLE`.
- `S_ADDR` moves to `S_ACK_WADDR` for the write address, to `S_ACK_RADDR` for the read address, and to `S_HOLD` for any other address.
- The receive chain runs `S_ACK_WADDR`→`S_INDEX`→`S_ACK_INDEX`→`S_COUNT`→`S_ACK_COUNT`→`S_WDATA`.
- `S_WDATA` moves to `S_ACK_WDATA` while the count has not run out, and to `S_HOLD` once it has. `S_ACK_WDATA` moves back to `S_WDATA`.
- The send chain runs `S_ACK_RADDR`→`S_TX`→`S_TX_ACK`. `S_TX_ACK` moves back to `S_TX` on an acknowledge and to `S_HOLD` on a not-acknowledge.

Top module: `smbus_idx_slave`

## Requirements
- R1: After reset, every control register reads 0x00 and the data line is released (`sda_oe` = 0).
- R2: The target acknowledges the address byte 0xDC (write) and 0xDD (read). Address bytes are seven bits 0x6E followed by the direction bit as the least significant bit. Any other address byte is not acknowledged, and the target then acknowledges nothing until the next start.
- R3: A write is: address 0xDC, index N, count X, then data bytes. Each of these bytes is acknowledged, and data byte k (from 0) is stored in register N+k for k < X.
- R4: Once X data bytes have been taken, a further data byte is not acknowledged and changes no register.
- R5: A data byte aimed at an index at or above the number of registers (9) is acknowledged and changes no register.
- R6: A read is: address 0xDC, index N, repeated start, address 0xDD. The target then sends the content of register 8 first, followed by registers N, N+1, and so on, most significant bit first, for as long as the controller acknowledges.
- R7: A read of an index at or above 9 returns 0x00.
- R8: After the controller answers a sent byte with a not-acknowledge, the target releases the data line and drives nothing until the next start.
- R9: A stop in any state returns the target to idle. Bytes already stored before the stop stay, and the remaining bytes of the block are not written.
- R10: `sda_oe` changes only while the serial clock input is low.
- R11: A start in any state, including in the middle of a byte, restarts the address phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least ten times the serial clock rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | High pulls the data line low |
| ctrl_regs | output | NREG*8 | All control registers; register k occupies bits 8k+7:8k |

## Verification
The bench builds the block with its default parameters: nine registers, the count kept in register 8, and two synchronizer stages. With only nine registers, indexes 9 and above are reached within a short block, so out-of-range writes and zero-valued reads run next to in-range ones. Because the count register is also the last one, a single read can cross from real data into the empty range. The serial clock runs at a half-period of twenty system clocks. That leaves enough room after each falling edge for the synchronized acknowledge and data bits to settle before the controller samples them.

// File: rtl/smb_pkg.sv
package smb_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_ADDR,
        S_ACK_WADDR,
        S_ACK_RADDR,
        S_INDEX,
        S_ACK_INDEX,
        S_COUNT,
        S_ACK_COUNT,
        S_WDATA,
        S_ACK_WDATA,
        S_TX,
        S_TX_ACK,
        S_HOLD
    } smb_state_e;

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], d_i};
    end

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/smb_regfile.sv
module smb_regfile #(
    parameter int NREG  = 9,
    parameter int PTR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [PTR_W-1:0]  waddr,
    input  logic [7:0]        wdata,
    input  logic [PTR_W-1:0]  raddr,
    output logic [7:0]        rdata,
    output logic [NREG*8-1:0] regs_flat
);
    logic [7:0] mem [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                             mem[g] <= '0;
            else if (we && (waddr == PTR_W'(g)))    mem[g] <= wdata;
        end
        assign regs_flat[g*8 +: 8] = mem[g];
    end

    always_comb begin
        rdata = '0;
        for (int k = 0; k < NREG; k++)
            if (raddr == PTR_W'(k)) rdata = mem[k];
    end
endmodule

// File: rtl/smbus_idx_slave.sv
module smbus_idx_slave
    import smb_pkg::*;
#(
    parameter int         NREG        = 9,
    parameter int         COUNT_IDX   = 8,
    parameter logic [6:0] DEV_ADDR    = 7'h6E,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    output logic [NREG*8-1:0] ctrl_regs
);
    localparam int         PTR_W   = 8;
    localparam logic [7:0] WR_BYTE = {DEV_ADDR, 1'b0};
    localparam logic [7:0] RD_BYTE = {DEV_ADDR, 1'b1};

    logic scl_s, sda_s, scl_d, sda_d;
    logic scl_rise, scl_fall, start_det, stop_det;

    smb_state_e       state;
    logic [3:0]       bitcnt;
    logic [7:0]       rx_sh, tx_sh;
    logic [PTR_W-1:0] ptr;
    logic [7:0]       remain;
    logic             host_ack;
    logic             wr_en;
    logic [PTR_W-1:0] raddr;
    logic [7:0]       rdata;
    logic             byte_end;

    smb_line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_scl_sync (
        .clk(clk), .rst_n(rst_n), .d_i(scl_i), .q_o(scl_s));
    smb_line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sda_sync (
        .clk(clk), .rst_n(rst_n), .d_i(sda_i), .q_o(sda_s));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    assign scl_rise  = scl_s & ~scl_d;
    assign scl_fall  = ~scl_s & scl_d;
    assign start_det = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
    assign byte_end  = scl_fall && (bitcnt == 4'd8);

    smb_regfile #(.NREG(NREG), .PTR_W(PTR_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .we(wr_en), .waddr(ptr), .wdata(rx_sh),
        .raddr(raddr), .rdata(rdata),
        .regs_flat(ctrl_regs));

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            bitcnt   <= '0;
            rx_sh    <= '0;
            tx_sh    <= '0;
            ptr      <= '0;
            remain   <= '0;
            host_ack <= 1'b0;
        end else if (stop_det) begin
            state <= S_IDLE;
        end else if (start_det) begin
            state  <= S_ADDR;
            bitcnt <= '0;
        end else begin
            unique case (state)
                S_IDLE, S_HOLD: ;
                S_ADDR, S_INDEX, S_COUNT, S_WDATA: begin
                    if (scl_rise) begin
                        rx_sh  <= {rx_sh[6:0], sda_s};
                        bitcnt <= bitcnt + 4'd1;
                    end else if (byte_end) begin
                        unique case (state)
                            S_ADDR:
                                if (rx_sh == WR_BYTE)      state <= S_ACK_WADDR;
                                else if (rx_sh == RD_BYTE) state <= S_ACK_RADDR;
                                else                       state <= S_HOLD;
                            S_INDEX: begin
                                ptr   <= rx_sh;
                                state <= S_ACK_INDEX;
                            end
                            S_COUNT: begin
                                remain <= rx_sh;
                                state  <= S_ACK_COUNT;
                            end
                            default:
                                if (remain != '0) begin
                                    ptr    <= ptr + 1'b1;
                                    remain <= remain - 8'd1;
                                    state  <= S_ACK_WDATA;
                                end else begin
                                    state  <= S_HOLD;
                                end
                        endcase
                    end
                end
                S_ACK_WADDR, S_ACK_INDEX, S_ACK_COUNT, S_ACK_WDATA: begin
                    if (scl_fall) begin
                        bitcnt <= '0;
                        unique case (state)
                            S_ACK_WADDR: state <= S_INDEX;
                            S_ACK_INDEX: state <= S_COUNT;
                            default:     state <= S_WDATA;
                        endcase
                    end
                end
                S_ACK_RADDR: begin
                    if (scl_fall) begin
                        bitcnt <= '0;
                        tx_sh  <= rdata;
                        state  <= S_TX;
                    end
                end
                S_TX: begin
                    if (scl_rise) begin
                        bitcnt <= bitcnt + 4'd1;
                    end else if (byte_end) begin
                        state <= S_TX_ACK;
                    end else if (scl_fall && bitcnt != '0) begin
                        tx_sh <= {tx_sh[6:0], 1'b0};
                    end
                end
                S_TX_ACK: begin
                    if (scl_rise) begin
                        host_ack <= ~sda_s;
                    end else if (scl_fall) begin
                        if (host_ack) begin
                            tx_sh  <= rdata;
                            ptr    <= ptr + 1'b1;
                            bitcnt <= '0;
                            state  <= S_TX;
                        end else begin
                            state <= S_HOLD;
                        end
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        sda_oe = 1'b0;
        wr_en  = 1'b0;
        raddr  = ptr;
        unique case (state)
            S_ACK_WADDR, S_ACK_INDEX, S_ACK_COUNT, S_ACK_WDATA: sda_oe = 1'b1;
            S_ACK_RADDR: begin
                sda_oe = 1'b1;
                raddr  = PTR_W'(COUNT_IDX);
            end
            S_TX:    sda_oe = ~tx_sh[7];
            S_WDATA: wr_en  = byte_end && (remain != '0) && !start_det && !stop_det;
            default: ;
        endcase
    end
endmodule

// File: rtl/smbus_idx_slave_chk.sv
module smbus_idx_slave_chk
    import smb_pkg::*;
#(
    parameter int REGS_W = 72
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_i,
    input logic              sda_oe,
    input smb_state_e        state,
    input logic              start_det,
    input logic              stop_det,
    input logic              wr_en,
    input logic [REGS_W-1:0] ctrl_regs
);
    // R10
    oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !scl_i);

    // R1
    idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE) |-> !sda_oe);

    // R8
    hold_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_HOLD) |-> !sda_oe);

    // R9
    stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (state == S_IDLE));

    // R11
    start_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det && !stop_det) |=> (state == S_ADDR));

    // R3
    regs_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(ctrl_regs));
endmodule

bind smbus_idx_slave smbus_idx_slave_chk #(.REGS_W(NREG*8)) u_chk (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
    .state(state), .start_det(start_det), .stop_det(stop_det),
    .wr_en(wr_en), .ctrl_regs(ctrl_regs));

// File: tb/smbus_idx_slave_bench.sv
module smbus_idx_slave_bench;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 20;
    localparam int NREG       = 9;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic m_low = 1'b0;
    logic sda_oe;
    logic [NREG*8-1:0] ctrl_regs;
    wire  sda_bus = ~(m_low | sda_oe);

    int checks = 0;
    int fails  = 0;
    int oe_viol = 0;
    bit done = 0;
    logic [7:0] exp_regs [NREG];
    logic prev_oe = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    smbus_idx_slave u_smbus_idx_slave (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
        .sda_oe(sda_oe), .ctrl_regs(ctrl_regs));

    // R10 monitor: output enable must not move while clock is high
    always @(posedge clk) begin
        if (rst_n && scl && (sda_oe !== prev_oe)) oe_viol++;
        prev_oe <= sda_oe;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_regs(input string req);
        for (int i = 0; i < NREG; i++)
            check(req, 32'(ctrl_regs[i*8 +: 8]), 32'(exp_regs[i]));
    endtask

    task automatic m_wait();
        repeat (HALF) @(negedge clk);
    endtask

    task automatic m_wbit(input logic b);
        m_low = ~b; m_wait(); scl = 1'b1; m_wait(); scl = 1'b0;
    endtask

    task automatic m_rbit(output logic b);
        m_low = 1'b0; m_wait(); scl = 1'b1;
        repeat (HALF/2) @(negedge clk);
        b = sda_bus;
        repeat (HALF/2) @(negedge clk);
        scl = 1'b0;
    endtask

    task automatic m_start();
        m_low = 1'b0; m_wait(); scl = 1'b1; m_wait(); m_low = 1'b1; m_wait(); scl = 1'b0;
    endtask

    task automatic m_stop();
        m_low = 1'b1; m_wait(); scl = 1'b1; m_wait(); m_low = 1'b0; m_wait();
    endtask

    task automatic m_wbyte(input logic [7:0] d, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) m_wbit(d[i]);
        m_rbit(b);
        ack = ~b;
    endtask

    task automatic m_rbyte(input logic give_ack, output logic [7:0] d);
        logic b;
        for (int i = 7; i >= 0; i--) begin m_rbit(b); d[i] = b; end
        m_wbit(~give_ack);
    endtask

    // Block write of n bytes (n may be below cnt: the stop then aborts)
    task automatic blk_write(input logic [7:0] idx, input logic [7:0] cnt,
                             input logic [7:0] d0, input logic [7:0] d1,
                             input logic [7:0] d2, input int n, input string req);
        logic ack;
        logic [7:0] d [3];
        d[0] = d0; d[1] = d1; d[2] = d2;
        m_start();
        m_wbyte(8'hDC, ack); check({req, " R2 addr ack"}, 32'(ack), 1);
        m_wbyte(idx, ack);   check({req, " R3 index ack"}, 32'(ack), 1);
        m_wbyte(cnt, ack);   check({req, " R3 count ack"}, 32'(ack), 1);
        for (int i = 0; i < n; i++) begin
            m_wbyte(d[i], ack);
            check({req, " data ack"}, 32'(ack), (i < cnt) ? 1 : 0);
            if (i < cnt && (int'(idx) + i) < NREG) exp_regs[int'(idx) + i] = d[i];
        end
        m_stop();
        check_regs({req, " regs"});
    endtask

    task automatic blk_read(input logic [7:0] idx, input int n, input string req);
        logic ack;
        logic [7:0] v;
        m_start();
        m_wbyte(8'hDC, ack); check({req, " R2 addr ack"}, 32'(ack), 1);
        m_wbyte(idx, ack);   check({req, " index ack"}, 32'(ack), 1);
        m_start();
        m_wbyte(8'hDD, ack); check({req, " R2 read addr ack"}, 32'(ack), 1);
        m_rbyte(1'b1, v);    check({req, " R6 count byte"}, 32'(v), 32'(exp_regs[8]));
        for (int i = 0; i < n; i++) begin
            m_rbyte(i != n - 1, v);
            check({req, " R6/R7 data"}, 32'(v),
                  ((int'(idx) + i) < NREG) ? 32'(exp_regs[int'(idx) + i]) : 0);
        end
    endtask

    task automatic t_reset();
        check("R1 sda released", 32'(sda_oe), 0);
        check("R1 regs zero", 32'(ctrl_regs[31:0]), 0);
        check_regs("R1");
    endtask

    task automatic t_write_basic();
        blk_write(8'd0, 8'd3, 8'hA1, 8'hB2, 8'hC3, 3, "R3 write 0..2");
        blk_write(8'd8, 8'd1, 8'h04, 8'h00, 8'h00, 1, "R3 write count reg");
    endtask

    task automatic t_over_count();
        blk_write(8'd4, 8'd1, 8'h55, 8'h66, 8'h00, 2, "R4 beyond count");
    endtask

    task automatic t_out_of_range();
        blk_write(8'd9, 8'd2, 8'hEE, 8'hDD, 8'h00, 2, "R5 index past end");
    endtask

    task automatic t_read_basic();
        blk_read(8'd1, 4, "R6 read from 1");
        m_stop();
    endtask

    task automatic t_read_past_end();
        logic [7:0] v;
        blk_read(8'd7, 3, "R7 read 7..9");
        // R8: target silent after the not-acknowledge
        m_rbyte(1'b0, v);
        check("R8 silent after nack", 32'(v), 32'hFF);
        m_stop();
    endtask

    task automatic t_bad_addr();
        logic ack;
        m_start();
        m_wbyte(8'hA0, ack); check("R2 foreign addr nack", 32'(ack), 0);
        m_wbyte(8'h00, ack); check("R2 silent after foreign addr", 32'(ack), 0);
        m_stop();
        check_regs("R2 regs");
    endtask

    task automatic t_abort();
        blk_write(8'd0, 8'd3, 8'h11, 8'h22, 8'h33, 2, "R9 stop mid block");
        check("R9 reg2 kept", 32'(ctrl_regs[23:16]), 32'hC3);
    endtask

    task automatic t_restart_mid_byte();
        logic ack;
        m_start();
        m_wbyte(8'hDC, ack);
        m_wbit(1'b1); m_wbit(1'b0); m_wbit(1'b1);
        blk_write(8'd2, 8'd1, 8'h77, 8'h00, 8'h00, 1, "R11 restart mid byte");
    endtask

    initial begin
        for (int i = 0; i < NREG; i++) exp_regs[i] = 8'h00;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        t_write_basic();
        t_over_count();
        t_out_of_range();
        t_read_basic();
        t_read_past_end();
        t_bad_addr();
        t_abort();
        t_restart_mid_byte();
        check("R10 oe moved while clock high", 32'(oe_viol), 0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule